// File: doc/BRIEF.md
# Blanked Cycle-by-Cycle Current Limiter with Fault Gate

This block sits beside the bridge pulse sequencer of a full-bridge converter controller. It watches a digital overcurrent flag from the current-sense comparator and ends the lower-switch pulse that is in progress. Every pulse opens with a blanking window of a programmable number of clock cycles, and the flag is ignored during that window so that the turn-on spike cannot cut the pulse. An overcurrent event never latches a fault. It shortens the present pulse only, and the next half-cycle on the opposite side starts as normal, so the converter can run in current limit indefinitely. Whenever no uncut pulse is active, the block asks for the current-sense node to be discharged.

The same block decides whether the bridge outputs may be driven at all. It applies hysteresis to a supply-voltage code, giving separate start and stop levels, and to a die-temperature code, giving a trip level and a lower release level. While either condition is present it holds a global output-disable high. Once both conditions have cleared, it releases the disable only when the sequencer marks the start of the next charge phase, so that no partial pulse can appear on restart.

Top module: `ilim_fault_guard`

## Requirements
- R1: The overcurrent flag has no effect during the first BLANK_CYC clock cycles of each pulse. The first cycle in which a pulse input is sampled high counts as cycle 0. The default BLANK_CYC is 9, which is 72 ns at 125 MHz.
- R2: Suppose the flag is sampled high while a pulse is active, uncut and outside its blanking window. Then `cut_strobe` is high for exactly one cycle after that same clock edge.
- R3: Each pulse produces at most one strobe. A new pulse on the opposite side, even one that starts in the cycle the previous pulse ends, is blanked afresh and can be cut again. Overcurrent never raises `bridge_off`.
- R4: An overcurrent flag has no effect while both pulse inputs are low.
- R5: `sense_dump` is registered. It is high after any edge at which both pulse inputs were sampled low, or at which the active pulse had been cut or was being cut. It is low while an uncut pulse is active.
- R6: The thermal fault sets when `temp_code` (1 °C per LSB) is at least 140. It clears when `temp_code` is at most 125, and it holds its state in between. It is clear at reset.
- R7: The undervoltage lockout sets when `supply_code` (50 mV per LSB) is below 140, which is 7.00 V. It releases when `supply_code` is at least 175, which is 8.75 V, and it holds its state in between. It is set at reset.
- R8: `bridge_off` goes high at the same edge at which a fault state becomes set. It goes low at the first edge at which `phase_start` is sampled high with no fault present, and not before that edge.
- R9: During reset, `cut_strobe` is 0, `sense_dump` is 1 and `bridge_off` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_trip | input | 1 | Digital overcurrent comparator flag |
| pulse_left | input | 1 | Left lower-switch pulse active |
| pulse_right | input | 1 | Right lower-switch pulse active |
| phase_start | input | 1 | Start of an oscillator charge phase |
| supply_code | input | SUP_W (8) | Supply voltage code, 50 mV per LSB |
| temp_code | input | TMP_W (8) | Die temperature code, 1 °C per LSB |
| cut_strobe | output | 1 | One-cycle request to end the active pulse |
| sense_dump | output | 1 | Request to discharge the current-sense node |
| bridge_off | output | 1 | Force every bridge output low |

## Verification
A wrong blanking count shows up on the first overcurrent event. The strobe appears one or more cycles away from cycle max(onset, BLANK_CYC), and sweeping the onset across the window exposes an off-by-one on either side. If the cut latch clears wrongly, or is not cleared on a new pulse start, the fault appears in the same pulse: either a second strobe or a `sense_dump` that drops back low. A stuck latch shows up on the next pulse instead, where no strobe arrives. A wrong hysteresis state is seen as `bridge_off` switching one code too early or too late during a supply or temperature ramp, and this is visible at the edge right after the boundary value is applied.

// File: rtl/ilim_pkg.sv
package ilim_pkg;

  // One step of a two-level hysteresis comparator.
  // rise_trips = 1: sets at x >= set_at, clears at x <= clr_at.
  // rise_trips = 0: sets at x <  set_at, clears at x >= clr_at.
  function automatic bit hyst_step(input int x, input bit cur,
                                   input int set_at, input int clr_at,
                                   input bit rise_trips);
    bit nxt;
    nxt = cur;
    if (rise_trips) begin
      if (x >= set_at)      nxt = 1'b1;
      else if (x <= clr_at) nxt = 1'b0;
    end else begin
      if (x < set_at)        nxt = 1'b1;
      else if (x >= clr_at)  nxt = 1'b0;
    end
    return nxt;
  endfunction

  // Output enable step: held while no fault, granted on a phase start.
  function automatic bit enable_step(input bit cur, input bit any_fault,
                                     input bit phase);
    return !any_fault && (cur || phase);
  endfunction

  // The blanking window is over once the counter is idle and no pulse starts now.
  function automatic bit window_open(input int count, input bit starting);
    return (count == 0) && !starting;
  endfunction

endpackage

// File: rtl/ilim_edge_detect.sv
module ilim_edge_detect #(
  parameter int NSIDE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSIDE-1:0] pulse_in,
  output logic [NSIDE-1:0] pulse_rise,
  output logic             any_active
);
  logic [NSIDE-1:0] prev_q;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[s] <= 1'b0;
      else        prev_q[s] <= pulse_in[s];
    end
    assign pulse_rise[s] = pulse_in[s] & ~prev_q[s];
  end

  assign any_active = |pulse_in;
endmodule

// File: rtl/ilim_pulse_cutter.sv
module ilim_pulse_cutter
  import ilim_pkg::*;
#(
  parameter int BLANK_CYC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_trip,
  input  logic any_active,
  input  logic any_start,
  output logic cut_strobe,
  output logic sense_dump,
  output logic blanking
);
  localparam int CW = $clog2(BLANK_CYC + 1);

  logic [CW-1:0] blank_cnt;
  logic          cut_q;
  logic          fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 blank_cnt <= '0;
    else if (any_start)         blank_cnt <= CW'(BLANK_CYC - 1);
    else if (blank_cnt != '0)   blank_cnt <= blank_cnt - CW'(1);
  end

  assign blanking = !window_open(int'(blank_cnt), any_start);
  assign fire     = any_active & ~blanking & oc_trip & ~cut_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cut_q <= 1'b0;
    else if (!any_active)  cut_q <= 1'b0;
    else if (any_start)    cut_q <= 1'b0;
    else if (fire)         cut_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cut_strobe <= 1'b0;
      sense_dump <= 1'b1;
    end else begin
      cut_strobe <= fire;
      sense_dump <= ~any_active | fire | (cut_q & ~any_start);
    end
  end

  // R1
  strobe_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cut_strobe |-> $past(any_active && !blanking && oc_trip))
    else $error("strobe raised inside blanking window");

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cut_strobe |=> !cut_strobe)
    else $error("two strobes in a row");

  // R5
  dump_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!any_active) |-> sense_dump)
    else $error("sense node not discharged while idle");

  // R2
  dump_on_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cut_strobe |-> sense_dump)
    else $error("sense node not discharged at cut");
endmodule

// File: rtl/ilim_hyst_monitor.sv
module ilim_hyst_monitor
  import ilim_pkg::*;
#(
  parameter int W          = 8,
  parameter int SET_AT     = 140,
  parameter int CLEAR_AT   = 125,
  parameter bit RISE_TRIPS = 1'b1,
  parameter bit RST_STATE  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic         state_nxt,
  output logic         state_q
);
  logic set_cond;
  logic clr_cond;

  if (RISE_TRIPS) begin : g_rise
    assign set_cond = int'(level) >= SET_AT;
    assign clr_cond = int'(level) <= CLEAR_AT;
  end else begin : g_fall
    assign set_cond = int'(level) <  SET_AT;
    assign clr_cond = int'(level) >= CLEAR_AT;
  end

  assign state_nxt = hyst_step(int'(level), state_q, SET_AT, CLEAR_AT, RISE_TRIPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RST_STATE;
    else        state_q <= state_nxt;
  end

  // R6 R7
  hyst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q) |-> $past(set_cond))
    else $error("fault set outside its threshold");

  // R6 R7
  hyst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state_q) |-> $past(clr_cond))
    else $error("fault cleared outside its threshold");
endmodule

// File: rtl/ilim_fault_gate.sv
module ilim_fault_gate
  import ilim_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic uv_nxt,
  input  logic hot_nxt,
  input  logic uv_q,
  input  logic hot_q,
  input  logic phase_start,
  output logic bridge_off
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable_step(en_q, uv_nxt | hot_nxt, phase_start);
  end

  assign bridge_off = ~en_q;

  // R8
  off_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_q || hot_q) |-> bridge_off)
    else $error("bridge enabled during a fault");

  // R8
  enable_on_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bridge_off) |-> $past(phase_start))
    else $error("bridge enabled away from a phase start");
endmodule

// File: rtl/ilim_fault_guard.sv
module ilim_fault_guard #(
  parameter int BLANK_CYC  = 9,
  parameter int SUP_W      = 8,
  parameter int TMP_W      = 8,
  parameter int UV_STOP    = 140,
  parameter int UV_START   = 175,
  parameter int TEMP_TRIP  = 140,
  parameter int TEMP_CLEAR = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oc_trip,
  input  logic             pulse_left,
  input  logic             pulse_right,
  input  logic             phase_start,
  input  logic [SUP_W-1:0] supply_code,
  input  logic [TMP_W-1:0] temp_code,
  output logic             cut_strobe,
  output logic             sense_dump,
  output logic             bridge_off
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0] pulse_vec;
  logic [NSIDE-1:0] pulse_rise;
  logic             any_active;
  logic             any_start;
  logic             blanking;
  logic             uv_nxt, uv_q;
  logic             hot_nxt, hot_q;

  assign pulse_vec = {pulse_right, pulse_left};
  assign any_start = |pulse_rise;

  ilim_edge_detect #(.NSIDE(NSIDE)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_in   (pulse_vec),
    .pulse_rise (pulse_rise),
    .any_active (any_active)
  );

  ilim_pulse_cutter #(.BLANK_CYC(BLANK_CYC)) u_cut (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_trip    (oc_trip),
    .any_active (any_active),
    .any_start  (any_start),
    .cut_strobe (cut_strobe),
    .sense_dump (sense_dump),
    .blanking   (blanking)
  );

  ilim_hyst_monitor #(
    .W(SUP_W), .SET_AT(UV_STOP), .CLEAR_AT(UV_START),
    .RISE_TRIPS(1'b0), .RST_STATE(1'b1)
  ) u_uv (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (supply_code),
    .state_nxt (uv_nxt),
    .state_q   (uv_q)
  );

  ilim_hyst_monitor #(
    .W(TMP_W), .SET_AT(TEMP_TRIP), .CLEAR_AT(TEMP_CLEAR),
    .RISE_TRIPS(1'b1), .RST_STATE(1'b0)
  ) u_hot (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (temp_code),
    .state_nxt (hot_nxt),
    .state_q   (hot_q)
  );

  ilim_fault_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .uv_nxt      (uv_nxt),
    .hot_nxt     (hot_nxt),
    .uv_q        (uv_q),
    .hot_q       (hot_q),
    .phase_start (phase_start),
    .bridge_off  (bridge_off)
  );

  // R4
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!any_active) |-> !cut_strobe)
    else $error("strobe without an active pulse");

  // R1
  start_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_start |-> blanking)
    else $error("pulse start not blanked");
endmodule

// File: tb/tb_ilim_fault_guard.sv
module tb_ilim_fault_guard;
  localparam int B = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc_trip = 1'b0, pulse_left = 1'b0, pulse_right = 1'b0, phase_start = 1'b0;
  logic [7:0] supply_code = 8'd0, temp_code = 8'd25;
  logic cut_strobe, sense_dump, bridge_off;

  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  ilim_fault_guard #(.BLANK_CYC(B)) dut (
    .clk(clk), .rst_n(rst_n), .oc_trip(oc_trip),
    .pulse_left(pulse_left), .pulse_right(pulse_right),
    .phase_start(phase_start), .supply_code(supply_code),
    .temp_code(temp_code), .cut_strobe(cut_strobe),
    .sense_dump(sense_dump), .bridge_off(bridge_off)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step; step;
    // R9 reset values
    chk(cut_strobe, 1'b0, "R9 strobe");
    chk(sense_dump, 1'b1, "R9 dump");
    chk(bridge_off, 1'b1, "R9 off");
    rst_n = 1'b1;

    // R7 supply ramp up then down, phase start always present
    phase_start = 1'b1;
    for (int v = 0; v < 256; v++) begin
      supply_code = 8'(v); step;
      chk(bridge_off, v < 175, "R7 rise");
    end
    for (int v = 255; v >= 0; v--) begin
      supply_code = 8'(v); step;
      chk(bridge_off, v < 140, "R7 fall");
    end

    // R8 restart waits for the phase start
    phase_start = 1'b0; supply_code = 8'd200; step;
    chk(bridge_off, 1'b1, "R8 no phase");
    step;
    chk(bridge_off, 1'b1, "R8 no phase 2");
    phase_start = 1'b1; step;
    chk(bridge_off, 1'b0, "R8 phase");

    // R6 temperature ramp
    for (int t = 100; t <= 200; t++) begin
      temp_code = 8'(t); step;
      chk(bridge_off, t >= 140, "R6 rise");
    end
    for (int t = 200; t >= 100; t--) begin
      temp_code = 8'(t); step;
      chk(bridge_off, t > 125, "R6 fall");
    end
    temp_code = 8'd150; step;
    chk(bridge_off, 1'b1, "R6 trip");
    phase_start = 1'b0; temp_code = 8'd100; step;
    chk(bridge_off, 1'b1, "R8 thermal clear no phase");
    phase_start = 1'b1; step;
    chk(bridge_off, 1'b0, "R8 thermal clear phase");
    phase_start = 1'b0; temp_code = 8'd25;

    // R1 R2 R5 blanking sweep over overcurrent onset d
    for (int d = 0; d < 15; d++) begin
      int cutc;
      cutc = (d > B) ? d : B;
      if (d % 2 == 0) pulse_left = 1'b1; else pulse_right = 1'b1;
      oc_trip = (d == 0);
      for (int c = 0; c <= 20; c++) begin
        step;
        chk(cut_strobe, c == cutc, $sformatf("R1 R2 strobe d=%0d c=%0d", d, c));
        chk(sense_dump, c >= cutc, $sformatf("R5 dump d=%0d c=%0d", d, c));
        oc_trip = (c + 1 >= d);
      end
      pulse_left = 1'b0; pulse_right = 1'b0; oc_trip = 1'b0; step;
      chk(sense_dump, 1'b1, "R5 idle dump");
      chk(bridge_off, 1'b0, "R3 no shutdown");
      step;
    end

    // R4 overcurrent with no pulse
    oc_trip = 1'b1;
    for (int c = 0; c < 10; c++) begin
      step;
      chk(cut_strobe, 1'b0, "R4 idle strobe");
      chk(sense_dump, 1'b1, "R4 idle dump");
    end

    // R3 back-to-back opposite sides with overcurrent held high
    pulse_left = 1'b1;
    for (int c = 0; c < 14; c++) begin
      step;
      chk(cut_strobe, c == B, "R3 left strobe");
    end
    pulse_left = 1'b0; pulse_right = 1'b1;
    for (int c = 0; c < 14; c++) begin
      step;
      chk(cut_strobe, c == B, "R3 right strobe");
      chk(sense_dump, c >= B, "R3 right dump");
      chk(bridge_off, 1'b0, "R3 running");
    end
    pulse_right = 1'b0; oc_trip = 1'b0; step;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule